// File: doc/BRIEF.md
# Run-Length Capture Encoder

This block compresses the serial sample stream of one logic-analyser channel into a variable-length prefix code of run lengths. It suits signals whose level stays put for at least seven samples between changes. It trades raw bandwidth for timing resolution: a fast capture clock keeps precise edge placement while the stored stream stays much smaller than the raw samples. One sample is taken per clock. Code words are packed into 32-bit words and written into a single page-sized buffer. The first bit of the page records the channel level at the moment capture starts.

Each code word stands for a count of samples and says whether the decoded level toggles afterwards. The six flip words cover run lengths seven to twelve. The two-bit no-flip word covers six samples and extends runs longer than twelve. Capture stops when the page is nearly full. The last partial word is padded with no-flip fill and written out. A run too short to be coded is stretched to the minimum length, and a sticky flag records that this happened.

Top module: `rlc_capture_encoder`

## Requirements
- R1: A start pulse while idle begins a page. The sample present with that pulse is stored as page bit 0, which is bit 31 of the word at address 0, and it counts as the first sample of the first run.
- R2: A run of 7 to 12 samples that ends with a level change is coded as follows: 7 is 01, 8 is 100, 9 is 101, 10 is 110, 11 is 1110, 12 is 1111. Each of these words implies a toggle after the run.
- R3: When a run reaches its 13th sample, the no-flip word 00 is emitted for six samples. It is emitted again every further six samples. The run finally ends with the flip word for the remaining 7 to 12 samples, so a run of 13 is coded 00 01.
- R4: Code bits are packed MSB first, in page order. Each full 32-bit word is written once, with a one-cycle write strobe, at addresses ascending from 0.
- R5: When fewer than four page bits remain free, capture stops and the full flag rises. The unused bits of the last word are zero (no-flip fill), and that word is written in the same cycle the flag rises. No further writes occur, and the flag holds until the next accepted start.
- R6: A run shorter than seven samples is stretched to seven by absorbing the samples that follow it, and the decoded level keeps its alternation. A sticky error flag is then set, and it is cleared only by an accepted start.
- R7: A start pulse during capture is ignored and does not disturb the stream.
- R8: With runs of at least seven samples, each code bit accounts for at least 8/3 samples. The page therefore takes at least (PAGE_BITS-4)*8/3 samples to fill.
- R9: After reset, and before any start, there are no writes, and the full and error flags are low. Samples have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Capture clock, one sample per cycle |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begin a new page (honoured only while idle) |
| smp_i | input | 1 | Channel sample |
| wr_en_o | output | 1 | Word write strobe |
| wr_addr_o | output | $clog2(PAGE_BITS/WORD_BITS) | Word address within the page |
| wr_data_o | output | WORD_BITS | Packed code word, earliest bit at the MSB |
| page_full_o | output | 1 | Page closed, capture stopped |
| short_err_o | output | 1 | Sticky: a run shorter than seven was stretched |

## Verification
A sample applied before a rising edge is coded at that edge. Any word that this code completes shows on the write port right after the same edge. The error flag also rises right after the edge that consumes the first sample which cannot yet end the short run. The full flag and the padded final write appear together, after the edge that consumed the sample whose code crossed the threshold. The bench drives and observes only at falling edges, so every result of sample k is visible at the observation that follows the drive of sample k. The number of samples consumed equals the count driven when the full flag is first seen. The sweep covers first runs from 7 to 18 (reaching the extension path) and second runs from 2 to 13 (reaching the stretch path). Every page is compared word by word against an image the bench builds arithmetically.

// File: rtl/rlc_pkg.sv
package rlc_pkg;
   localparam int CODE_W  = 4;   // longest code word
   localparam int MIN_RUN = 7;   // shortest run that can end with a flip
   localparam int MAX_RUN = 12;  // longest single flip word
   localparam int EXT_RUN = 6;   // samples covered by the no-flip word

   typedef struct packed {
      logic [CODE_W-1:0] bits;   // right-aligned code
      logic [2:0]        len;    // valid bits in 'bits'
   } rlc_code_t;
endpackage

// File: rtl/rlc_code_select.sv
module rlc_code_select
   import rlc_pkg::*;
#(
   parameter int CNT_W = 4
) (
   input  logic             ext_i,
   input  logic [CNT_W-1:0] cnt_i,
   output rlc_code_t        code_o
);
   always_comb begin
      code_o = '{bits: 4'b0000, len: 3'd2};
      if (!ext_i) begin
         case (cnt_i)
            CNT_W'(7):  code_o = '{bits: 4'b0001, len: 3'd2};
            CNT_W'(8):  code_o = '{bits: 4'b0100, len: 3'd3};
            CNT_W'(9):  code_o = '{bits: 4'b0101, len: 3'd3};
            CNT_W'(10): code_o = '{bits: 4'b0110, len: 3'd3};
            CNT_W'(11): code_o = '{bits: 4'b1110, len: 3'd4};
            default:    code_o = '{bits: 4'b1111, len: 3'd4};
         endcase
      end
   end
endmodule

// File: rtl/rlc_run_tracker.sv
module rlc_run_tracker
   import rlc_pkg::*;
#(
   parameter int CNT_W = 4
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             load_i,
   input  logic             init_i,
   input  logic             run_i,
   input  logic             smp_i,
   output logic             emit_o,
   output logic             ext_o,
   output logic [CNT_W-1:0] cnt_o,
   output logic             err_o
);
   localparam logic [CNT_W-1:0] MinC  = CNT_W'(MIN_RUN);
   localparam logic [CNT_W-1:0] MaxC  = CNT_W'(MAX_RUN);
   localparam logic [CNT_W-1:0] AfterExt = CNT_W'(MAX_RUN + 1 - EXT_RUN);

   logic             lvl_q;
   logic [CNT_W-1:0] cnt_q;
   logic             err_q;
   logic             same;
   logic             at_max;
   logic             long_enough;

   assign same        = (smp_i == lvl_q);
   assign at_max      = (cnt_q == MaxC);
   assign long_enough = (cnt_q >= MinC);

   assign emit_o = run_i & (same ? at_max : long_enough);
   assign ext_o  = same;
   assign cnt_o  = cnt_q;
   assign err_o  = err_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         lvl_q <= 1'b0;
         cnt_q <= '0;
         err_q <= 1'b0;
      end else if (load_i) begin
         lvl_q <= init_i;
         cnt_q <= CNT_W'(1);
         err_q <= 1'b0;
      end else if (run_i) begin
         if (same) begin
            cnt_q <= at_max ? AfterExt : cnt_q + CNT_W'(1);
         end else if (long_enough) begin
            lvl_q <= smp_i;
            cnt_q <= CNT_W'(1);
         end else begin
            cnt_q <= cnt_q + CNT_W'(1);
            err_q <= 1'b1;
         end
      end
   end
endmodule

// File: rtl/rlc_bit_packer.sv
module rlc_bit_packer
   import rlc_pkg::*;
#(
   parameter int WORD_BITS = 32,
   parameter int PAGE_BITS = 2048,
   localparam int ADDR_W   = $clog2(PAGE_BITS / WORD_BITS)
) (
   input  logic                 clk_i,
   input  logic                 rst_ni,
   input  logic                 load_i,
   input  logic                 init_i,
   input  logic                 emit_i,
   input  rlc_code_t            code_i,
   output logic                 busy_o,
   output logic                 wr_en_o,
   output logic [ADDR_W-1:0]    wr_addr_o,
   output logic [WORD_BITS-1:0] wr_data_o,
   output logic                 full_o
);
   localparam int ACC_W  = WORD_BITS + CODE_W;
   localparam int NACC_W = $clog2(ACC_W + 1);
   localparam int USED_W = $clog2(PAGE_BITS + 1);
   localparam logic [USED_W-1:0] FillLimit = USED_W'(PAGE_BITS - CODE_W);

   logic [ACC_W-1:0]  acc_q;
   logic [NACC_W-1:0] nacc_q;
   logic [USED_W-1:0] used_q;
   logic [ADDR_W-1:0] addr_q;
   logic              busy_q;

   logic [ACC_W-1:0]  code_top;
   logic [ACC_W-1:0]  placed;
   logic [2:0]        len_eff;
   logic [ACC_W-1:0]  acc_sum;
   logic [NACC_W-1:0] n_sum;
   logic [USED_W-1:0] used_sum;
   logic              spill;
   logic              last;

   always_comb begin
      code_top = {code_i.bits, {(ACC_W-CODE_W){1'b0}}};
      placed   = (code_top << (CODE_W - int'(code_i.len))) >> nacc_q;
      len_eff  = emit_i ? code_i.len : 3'd0;
      acc_sum  = emit_i ? (acc_q | placed) : acc_q;
      n_sum    = nacc_q + NACC_W'(len_eff);
      used_sum = used_q + USED_W'(len_eff);
      spill    = (n_sum >= NACC_W'(WORD_BITS));
      last     = (used_sum > FillLimit);
   end

   assign busy_o = busy_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         acc_q     <= '0;
         nacc_q    <= '0;
         used_q    <= '0;
         addr_q    <= '0;
         busy_q    <= 1'b0;
         full_o    <= 1'b0;
         wr_en_o   <= 1'b0;
         wr_addr_o <= '0;
         wr_data_o <= '0;
      end else begin
         wr_en_o <= 1'b0;
         if (load_i) begin
            acc_q  <= {init_i, {(ACC_W-1){1'b0}}};
            nacc_q <= NACC_W'(1);
            used_q <= USED_W'(1);
            addr_q <= '0;
            busy_q <= 1'b1;
            full_o <= 1'b0;
         end else if (busy_q) begin
            used_q <= used_sum;
            if (spill) begin
               wr_en_o   <= 1'b1;
               wr_addr_o <= addr_q;
               wr_data_o <= acc_sum[ACC_W-1 -: WORD_BITS];
               addr_q    <= addr_q + ADDR_W'(1);
               acc_q     <= acc_sum << WORD_BITS;
               nacc_q    <= n_sum - NACC_W'(WORD_BITS);
            end else begin
               acc_q  <= acc_sum;
               nacc_q <= n_sum;
            end
            if (last) begin
               busy_q <= 1'b0;
               full_o <= 1'b1;
               if (!spill) begin
                  wr_en_o   <= 1'b1;
                  wr_addr_o <= addr_q;
                  wr_data_o <= acc_sum[ACC_W-1 -: WORD_BITS];
               end
            end
         end
      end
   end
endmodule

// File: rtl/rlc_capture_encoder.sv
module rlc_capture_encoder
   import rlc_pkg::*;
#(
   parameter int WORD_BITS = 32,
   parameter int PAGE_BITS = 2048,
   localparam int ADDR_W   = $clog2(PAGE_BITS / WORD_BITS)
) (
   input  logic                 clk_i,
   input  logic                 rst_ni,
   input  logic                 start_i,
   input  logic                 smp_i,
   output logic                 wr_en_o,
   output logic [ADDR_W-1:0]    wr_addr_o,
   output logic [WORD_BITS-1:0] wr_data_o,
   output logic                 page_full_o,
   output logic                 short_err_o
);
   localparam int CNT_W = $clog2(MAX_RUN + 1);

   if (WORD_BITS < 8) begin : g_bad_word
      $error("WORD_BITS must be at least 8");
   end
   if (PAGE_BITS % WORD_BITS != 0) begin : g_bad_align
      $error("PAGE_BITS must be a multiple of WORD_BITS");
   end
   if (PAGE_BITS < 2 * WORD_BITS) begin : g_bad_page
      $error("PAGE_BITS must hold at least two words");
   end

   logic             busy;
   logic             load;
   logic             emit;
   logic             ext;
   logic [CNT_W-1:0] cnt;
   rlc_code_t        code;

   assign load = start_i & ~busy;

   rlc_run_tracker #(.CNT_W(CNT_W)) u_track (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .load_i (load),
      .init_i (smp_i),
      .run_i  (busy),
      .smp_i  (smp_i),
      .emit_o (emit),
      .ext_o  (ext),
      .cnt_o  (cnt),
      .err_o  (short_err_o)
   );

   rlc_code_select #(.CNT_W(CNT_W)) u_code (
      .ext_i  (ext),
      .cnt_i  (cnt),
      .code_o (code)
   );

   rlc_bit_packer #(.WORD_BITS(WORD_BITS), .PAGE_BITS(PAGE_BITS)) u_pack (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .load_i    (load),
      .init_i    (smp_i),
      .emit_i    (emit),
      .code_i    (code),
      .busy_o    (busy),
      .wr_en_o   (wr_en_o),
      .wr_addr_o (wr_addr_o),
      .wr_data_o (wr_data_o),
      .full_o    (page_full_o)
   );
endmodule

// File: rtl/rlc_capture_encoder_chk.sv
module rlc_capture_encoder_chk #(
   parameter int WORD_BITS = 32,
   parameter int PAGE_BITS = 2048,
   localparam int ADDR_W   = $clog2(PAGE_BITS / WORD_BITS)
) (
   input logic              clk_i,
   input logic              rst_ni,
   input logic              start_i,
   input logic              wr_en_o,
   input logic [ADDR_W-1:0] wr_addr_o,
   input logic              page_full_o,
   input logic              short_err_o
);
   localparam logic [ADDR_W-1:0] LastAddr = ADDR_W'(PAGE_BITS / WORD_BITS - 1);

   logic [ADDR_W-1:0] exp_addr;
   logic              seen_start;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         exp_addr   <= '0;
         seen_start <= 1'b0;
      end else begin
         if (wr_en_o) exp_addr <= page_full_o ? '0 : exp_addr + ADDR_W'(1);
         if (start_i) seen_start <= 1'b1;
      end
   end

   p_addr_order_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      wr_en_o |-> wr_addr_o == exp_addr);

   p_full_last_word_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(page_full_o) |-> wr_en_o && wr_addr_o == LastAddr);

   p_full_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      page_full_o && !start_i |=> page_full_o);

   p_quiet_after_full_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      page_full_o && $past(page_full_o) |-> !wr_en_o);

   p_err_sticky_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      short_err_o && !start_i |=> short_err_o);

   p_idle_no_write_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      wr_en_o |-> seen_start);
endmodule

bind rlc_capture_encoder rlc_capture_encoder_chk #(
   .WORD_BITS(WORD_BITS),
   .PAGE_BITS(PAGE_BITS)
) u_chk (
   .clk_i       (clk_i),
   .rst_ni      (rst_ni),
   .start_i     (start_i),
   .wr_en_o     (wr_en_o),
   .wr_addr_o   (wr_addr_o),
   .page_full_o (page_full_o),
   .short_err_o (short_err_o)
);

// File: tb/test_rlc_capture_encoder.sv
`timescale 1ns/1ps
module test_rlc_capture_encoder;
   localparam int WB = 32;
   localparam int PG = 128;
   localparam int NW = PG / WB;
   localparam int AW = $clog2(NW);

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start = 1'b0;
   logic          smp = 1'b0;
   logic          wr_en;
   logic [AW-1:0] wr_addr;
   logic [WB-1:0] wr_data;
   logic          full;
   logic          err;

   int vectors = 0;
   int miscompares = 0;
   bit finished = 1'b0;

   bit            exp_bits [PG];
   int            pos;
   logic [WB-1:0] got [NW];
   bit            got_v [NW];

   always #4 clk = ~clk;

   rlc_capture_encoder #(.WORD_BITS(WB), .PAGE_BITS(PG)) i_rlc_capture_encoder (
      .clk_i(clk), .rst_ni(rst_n), .start_i(start), .smp_i(smp),
      .wr_en_o(wr_en), .wr_addr_o(wr_addr), .wr_data_o(wr_data),
      .page_full_o(full), .short_err_o(err)
   );

   task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] expv);
      vectors++;
      if (!ok) begin
         miscompares++;
         $display("FAIL %s actual=%h expected=%h", tag, act, expv);
      end
   endtask

   task automatic put(input int v, input int len);
      for (int i = len - 1; i >= 0; i--) begin
         exp_bits[pos] = v[i];
         pos++;
      end
   endtask

   // R2/R3 code table and extension, computed from the run length
   task automatic put_run(input int len);
      int rem = len;
      while (rem > 12) begin
         put(0, 2);
         rem -= 6;
      end
      case (rem)
         7:  put(1, 2);
         8:  put(4, 3);
         9:  put(5, 3);
         10: put(6, 3);
         11: put(14, 4);
         default: put(15, 4);
      endcase
   endtask

   task automatic run_page(input bit init, input int r1, input int r2);
      int runs [3];
      int debt = 0;
      bit err_exp = 1'b0;
      int k = 0;
      bit done = 1'b0;
      logic [WB-1:0] ew;
      runs[0] = r1; runs[1] = r2; runs[2] = 9;
      for (int i = 0; i < PG; i++) exp_bits[i] = 1'b0;
      pos = 0;
      put(int'(init), 1);
      for (int i = 0; i < 3; i++) begin
         int eff = runs[i] - debt;
         if (eff < 7) begin
            err_exp = 1'b1;
            debt = 7 - eff;
            eff = 7;
         end else begin
            debt = 0;
         end
         put_run(eff);
      end
      for (int i = 0; i < NW; i++) got_v[i] = 1'b0;

      while (!done && k < 4000) begin
         @(negedge clk);
         if (k > 0) begin
            if (wr_en) begin
               got[wr_addr] = wr_data;
               got_v[wr_addr] = 1'b1;
            end
            if (full) done = 1'b1;
         end
         if (!done) begin
            k++;
            start = (k == 1) || (k == 5);   // R7: second pulse lands mid-run
            if (k <= r1) smp = init;
            else if (k <= r1 + r2) smp = ~init;
            else if (k <= r1 + r2 + 9) smp = init;
            else smp = ~init;
         end
      end
      start = 1'b0;

      check(done, "R5 page never filled", 32'(k), 32'(0));
      check(got_v[0] && got[0][WB-1] == init, "R1 initial level bit",
            32'(got[0][WB-1]), 32'(init));
      for (int w = 0; w < NW; w++) begin
         for (int i = 0; i < WB; i++) ew[WB-1-i] = exp_bits[w*WB + i];
         check(got_v[w] && got[w] == ew, $sformatf("R2 R3 R4 R7 word %0d r1=%0d r2=%0d", w, r1, r2),
               got[w], ew);
      end
      check(err == err_exp, $sformatf("R6 short flag r1=%0d r2=%0d", r1, r2),
            32'(err), 32'(err_exp));
      check(k * 3 >= (PG - 4) * 8, "R8 samples per page", 32'(k), 32'((PG - 4) * 8 / 3));

      for (int i = 0; i < 6; i++) begin
         @(negedge clk);
         check(!wr_en && full, "R5 quiet after full", {30'd0, wr_en, full}, 32'd1);
         smp = ~smp;
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         miscompares++;
         $display("FAIL watchdog expired");
         $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
         $finish;
      end
   end

   initial begin
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check(!wr_en && !full && !err, "R9 reset state", {29'd0, wr_en, full, err}, 32'd0);
      for (int i = 0; i < 20; i++) begin
         smp = i[1];
         @(negedge clk);
         check(!wr_en && !full && !err, "R9 idle without start", {29'd0, wr_en, full, err}, 32'd0);
      end
      for (int r1 = 7; r1 <= 18; r1++) begin
         for (int r2 = 2; r2 <= 13; r2++) begin
            run_page(1'((r1 + r2) & 1), r1, r2);
         end
      end
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end
endmodule